// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Model

This block is a cycle-accurate, synthesizable model of a small pipelined synchronous SRAM. The word is 32 bits wide and split into four byte lanes. All control, address and write data are taken on the rising clock edge. Read data passes through one internal read stage and then an output register, so a read accepted at edge k is on the bus after edge k+1. An access begins on one of two start strobes. The processor strobe is honoured only while the first chip select is active. The controller strobe takes effect whenever the processor strobe does not. A two-bit wrapping burst counter steps the low address bits during a burst, in either linear or interleaved order. The order is chosen by a static mode input.

The shared data bus is split into a write-data input, a read-data output and an output drive enable. An enclosing wrapper can turn these into a tri-state pin. The memory answers one command per clock and applies no back-pressure. A command has no valid/ready pair: the strobes mark a new access, and the absence of a strobe continues the current one. The enable tells the consumer when the read-data output is meaningful.

Top module: `sburst_sram`

## Requirements
- R1: A read accepted at rising edge k puts the addressed word on `dout`, with `dout_en` high, during the cycle after edge k+1. This holds when `oe_n` is low, the read is not the first of an access after a deselect, edge k+1 performs no write and edge k+1 does not deselect.
- R2: A start needs a strobe low and all three selects active (`sel1_n`=0, `sel2`=1, `sel3_n`=0). A controller start is a read when `gwr_n`=1 and either `bwr_n`=1 or all `bsel_n` bits are 1. Otherwise it is a write.
- R3: While `sel1_n` is high, a low `pstb_n` is ignored. A low `cstb_n` in the same cycle is treated as a controller strobe. If no strobe is taken, the running burst continues.
- R4: A processor start always reads its address and ignores the write controls and `adv_n`. A following strobe-free cycle with write controls active writes `din` into the burst address (R4 two-cycle write).
- R5: A controller start with write controls active writes `din` at that same edge, and `adv_n` is ignored in that cycle.
- R6: Byte lane i is `din[8i+7:8i]`, selected by `bsel_n[i]`=0. With `gwr_n`=0 all four lanes are written whatever `bsel_n` holds. Otherwise, with `bwr_n`=0, only the selected lanes are written. Unselected lanes keep their contents, and `bsel_n` has no effect while `bwr_n`=1.
- R7: After reset, and for the first read of an access that starts from the deselected state, `dout_en` stays low during that read's data cycle.
- R8: During the cycle after any edge that performs a write, `dout_en` is low regardless of `oe_n`.
- R9: A strobe taken while any select is inactive deselects the device. `dout_en` is low in the next cycle, and pending read data is dropped. Strobe-free cycles then perform no access until a new start.
- R10: In a strobe-free cycle after a start, `adv_n`=0 steps the two-bit burst count, which wraps after four. The low two address bits are base+count mod 4 when `burst_linear`=1, and base XOR count when it is 0. The upper bits stay fixed. With `adv_n`=1 the address is held. The cycle reads or writes according to its write controls.
- R11: `oe_n` acts without a clock: while it is high `dout_en` is low, and when it goes low during a valid data cycle `dout_en` rises in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state (array not cleared) |
| burst_linear | input | 1 | Static burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address taken on a start |
| pstb_n | input | 1 | Processor start strobe, active low |
| cstb_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | First chip select, active low; also qualifies `pstb_n` |
| sel2 | input | 1 | Second chip select, active high |
| sel3_n | input | 1 | Third chip select, active low |
| gwr_n | input | 1 | Global write, active low; writes all lanes |
| bwr_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane byte select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data from the output register |
| dout_en | output | 1 | High when `dout` should be driven onto the bus |

## Verification
The hardest case to reach is the interaction between the first-cycle suppression after a deselect and the two-cycle processor write. Both depend on state that has no output of its own: whether the device is selected, and where the burst counter stands. The stimulus therefore deselects on purpose with a strobe and an inactive third select. It then starts fresh reads and processor writes while the write controls are driven to values that must be ignored, and it places writes right after reads so that the drive enable has to drop over data that is already in flight. Memory effects are judged only by reading every word back at the end.

// File: rtl/sburst_pkg.sv
`timescale 1ns/1ps
package sburst_pkg;
  // width of the wrapping burst counter (four beats)
  localparam int CNT_W = 2;

  // tag travelling alongside read data through the pipeline
  typedef struct packed {
    logic valid;
    logic fresh;   // first read after a deselected state
  } rd_tag_t;
endpackage

// File: rtl/sburst_addr_gen.sv
`timescale 1ns/1ps
module sburst_addr_gen import sburst_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              linear,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] eff_addr
);
  logic [ADDR_W-1:0] base_q, base_sel;
  logic [CNT_W-1:0]  cnt_q, cnt_nx, low;

  always_comb begin
    base_sel = load ? load_addr : base_q;
    if (load)     cnt_nx = '0;
    else if (adv) cnt_nx = cnt_q + 1'b1;
    else          cnt_nx = cnt_q;
    low      = linear ? (base_sel[CNT_W-1:0] + cnt_nx) : (base_sel[CNT_W-1:0] ^ cnt_nx);
    eff_addr = {base_sel[ADDR_W-1:CNT_W], low};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_sel;
      cnt_q  <= cnt_nx;
    end
  end

  // upper address bits never move inside a burst
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !load |-> (eff_addr[ADDR_W-1:CNT_W] == base_q[ADDR_W-1:CNT_W])); // R10
endmodule

// File: rtl/sburst_lane.sv
`timescale 1ns/1ps
module sburst_lane #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (rd) rdata     <= mem[addr];
  end
endmodule

// File: rtl/sburst_sram.sv
`timescale 1ns/1ps
module sburst_sram import sburst_pkg::*; #(
  parameter  int ADDR_W = 6,
  parameter  int LANE_W = 8,
  parameter  int LANES  = 4,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_linear,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pstb_n,
  input  logic              cstb_n,
  input  logic              adv_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              gwr_n,
  input  logic              bwr_n,
  input  logic [LANES-1:0]  bsel_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic sel_ok, p_hit, c_hit, start, desel, begin_acc, cont;
  logic wr_ctl, do_wr, do_rd, adv_step;
  logic [LANES-1:0]  lane_mask, lane_we;
  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] s1_data, dout_q;
  logic    active_q, wr_last_q;
  rd_tag_t s1_q, s2_q;

  // command decode on the sampled pins
  always_comb begin
    sel_ok    = !sel1_n && sel2 && !sel3_n;
    p_hit     = !pstb_n && !sel1_n;          // processor strobe needs select 1
    c_hit     = !cstb_n && !p_hit;
    start     = p_hit || c_hit;
    desel     = start && !sel_ok;
    begin_acc = start && sel_ok;
    cont      = !start && active_q;
    lane_mask = !gwr_n ? '1 : (!bwr_n ? ~bsel_n : '0);
    wr_ctl    = |lane_mask;
    do_wr     = (begin_acc && c_hit && wr_ctl) || (cont && wr_ctl);
    do_rd     = (begin_acc && (p_hit || !wr_ctl)) || (cont && !wr_ctl);
    adv_step  = cont && !adv_n;
    lane_we   = {LANES{do_wr}} & lane_mask;
  end

  sburst_addr_gen #(.ADDR_W(ADDR_W)) u_addr_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (begin_acc),
    .adv       (adv_step),
    .linear    (burst_linear),
    .load_addr (addr),
    .eff_addr  (eff_addr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sburst_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk   (clk),
      .we    (lane_we[g]),
      .rd    (do_rd),
      .addr  (eff_addr),
      .wdata (din[g*LANE_W +: LANE_W]),
      .rdata (s1_data[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      s1_q      <= '0;
      s2_q      <= '0;
      wr_last_q <= 1'b0;
    end else begin
      if (begin_acc)  active_q <= 1'b1;
      else if (desel) active_q <= 1'b0;
      s1_q.valid <= do_rd;
      s1_q.fresh <= begin_acc && !active_q;
      s2_q       <= desel ? '0 : s1_q;
      wr_last_q  <= do_wr;
    end
  end

  always_ff @(posedge clk) dout_q <= s1_data;

  assign dout    = dout_q;
  assign dout_en = s2_q.valid && !s2_q.fresh && !wr_last_q && !oe_n;

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !dout_en); // R9
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr |=> !dout_en); // R8
  AST_FRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_acc && !active_q && do_rd) |-> ##2 !dout_en); // R7
  AST_PSTB_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstb_n && sel1_n && cstb_n) |=> (active_q == $past(active_q))); // R3
  AST_PSTB_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    p_hit |-> (lane_we == '0)); // R4
endmodule

// File: tb/test_sburst_sram.sv
`timescale 1ns/1ps
module test_sburst_sram;
  localparam int AW = 6;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_linear = 1'b1;
  logic [AW-1:0] addr = '0;
  logic pstb_n = 1, cstb_n = 1, adv_n = 1;
  logic sel1_n = 0, sel2 = 1, sel3_n = 0;
  logic gwr_n = 1, bwr_n = 1, oe_n = 0;
  logic [3:0]  bsel_n = 4'hF;
  logic [31:0] din = '0;
  logic [31:0] dout;
  logic        dout_en;

  int compared = 0, mismatched = 0;
  string phase = "R7 reset";

  always #2.5 clk = ~clk;   // 200 MHz

  sburst_sram i_sburst_sram (
    .clk(clk), .rst_n(rst_n), .burst_linear(burst_linear), .addr(addr),
    .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .bsel_n(bsel_n), .oe_n(oe_n),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] mm [WORDS];
  bit m_active, p1_v, p1_f, b_v, b_f, b_wr;
  logic [31:0] p1_d, b_d;
  int m_start, m_cnt;

  always @(posedge clk) begin
    bit selok, pgo, cgo, wctl, rd, wr, fr;
    int a, low;
    if (!rst_n) begin
      m_active = 0; p1_v = 0; p1_f = 0; b_v = 0; b_f = 0; b_wr = 0;
    end else begin
      selok = (sel1_n == 0) && (sel2 == 1) && (sel3_n == 0);
      pgo   = (pstb_n == 0) && (sel1_n == 0);
      cgo   = (cstb_n == 0) && !pgo;
      wctl  = (gwr_n == 0) || ((bwr_n == 0) && (bsel_n != 4'hF));
      rd = 0; wr = 0; fr = 0; a = 0;
      b_v = p1_v; b_f = p1_f; b_d = p1_d; b_wr = 0;
      p1_v = 0; p1_f = 0;
      if (pgo || cgo) begin
        if (!selok) begin
          m_active = 0; b_v = 0;
        end else begin
          fr = !m_active; m_active = 1;
          m_start = int'(addr); m_cnt = 0; a = m_start;
          rd = pgo || !wctl; wr = cgo && wctl;
        end
      end else if (m_active) begin
        if (adv_n == 0) m_cnt = (m_cnt + 1) % 4;
        low = burst_linear ? ((m_start % 4) + m_cnt) % 4 : ((m_start % 4) ^ m_cnt);
        a = (m_start / 4) * 4 + low;
        rd = !wctl; wr = wctl;
      end
      if (rd) begin p1_v = 1; p1_f = fr; p1_d = mm[a]; end
      if (wr) begin
        for (int i = 0; i < 4; i++)
          if (gwr_n == 0 || (bwr_n == 0 && bsel_n[i] == 0)) mm[a][8*i +: 8] = din[8*i +: 8];
        b_wr = 1;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check_now();
    bit exp_en;
    exp_en = b_v && !b_f && !b_wr && (oe_n == 0);
    compared++;
    if (dout_en !== exp_en) begin
      mismatched++;
      $display("FAIL %s: dout_en=%0b expected %0b at %0t", phase, dout_en, exp_en, $time);
    end else if (exp_en && dout !== b_d) begin
      mismatched++;
      $display("FAIL %s: dout=%h expected %h at %0t", phase, dout, b_d, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    check_now();
    #1;
  endtask

  task automatic set_idle();
    pstb_n = 1; cstb_n = 1; adv_n = 1; gwr_n = 1; bwr_n = 1; bsel_n = 4'hF;
    sel1_n = 0; sel2 = 1; sel3_n = 0;
  endtask

  task automatic c_rd(input int a);
    set_idle(); cstb_n = 0; addr = AW'(a); tick();
  endtask

  task automatic c_wr(input int a, input logic [31:0] d, input logic g, input logic b,
                      input logic [3:0] bs, input logic av);
    set_idle(); cstb_n = 0; addr = AW'(a); din = d;
    gwr_n = g; bwr_n = b; bsel_n = bs; adv_n = av; tick();
  endtask

  task automatic cont(input logic av, input logic g, input logic b,
                      input logic [3:0] bs, input logic [31:0] d);
    set_idle(); adv_n = av; gwr_n = g; bwr_n = b; bsel_n = bs; din = d; tick();
  endtask

  task automatic desel();
    set_idle(); cstb_n = 0; sel3_n = 1; tick();
  endtask

  initial begin
    #100000;
    mismatched++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    phase = "R7 reset";
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1;
    tick();

    phase = "R5 fill with adv ignored";
    for (int a = 0; a < WORDS; a++) c_wr(a, {8'(a), 8'(~a), 8'(a * 3), 8'(a + 77)}, 0, 1, 4'hF, 0);

    phase = "R1 R2 reads";
    for (int a = 5; a < 12; a++) c_rd(a);
    set_idle(); tick(); tick();

    phase = "R9 deselect";
    desel(); set_idle(); tick(); tick();

    phase = "R7 first read after deselect";
    c_rd(20); c_rd(21); c_rd(22); c_rd(23);

    phase = "R2 byte enable without lanes reads";
    c_wr(30, 32'hDEADBEEF, 1, 0, 4'hF, 1); c_rd(30); c_rd(31);

    phase = "R6 byte lanes";
    c_wr(40, 32'hAABBCCDD, 1, 0, 4'b1010, 1);
    c_wr(41, 32'h11223344, 1, 0, 4'b0101, 1);
    c_wr(42, 32'h55667788, 0, 0, 4'b1111, 1);
    c_wr(43, 32'h99AABBCC, 1, 1, 4'b0000, 1);
    for (int a = 40; a < 44; a++) c_rd(a);

    phase = "R4 processor two-cycle write";
    set_idle(); pstb_n = 0; addr = AW'(50); gwr_n = 0; din = 32'hFFFF0000; adv_n = 0; tick();
    cont(1, 1, 0, 4'b1100, 32'h12345678);
    c_rd(50); c_rd(51);
    set_idle(); pstb_n = 0; addr = AW'(52); tick();
    cont(0, 0, 1, 4'hF, 32'hCAFEF00D);
    c_rd(52); c_rd(53);

    phase = "R8 write tristate";
    c_rd(10); c_wr(11, 32'h0BADF00D, 0, 1, 4'hF, 1); c_rd(11); c_rd(12); c_rd(13);

    phase = "R10 linear burst";
    burst_linear = 1;
    c_rd(26);
    for (int i = 0; i < 5; i++) cont(0, 1, 1, 4'hF, '0);
    cont(1, 1, 1, 4'hF, '0); cont(1, 1, 1, 4'hF, '0);
    cont(0, 0, 1, 4'hF, 32'h76543210);
    c_rd(24); for (int i = 0; i < 4; i++) cont(0, 1, 1, 4'hF, '0);

    phase = "R10 interleaved burst";
    burst_linear = 0;
    c_rd(27); for (int i = 0; i < 5; i++) cont(0, 1, 1, 4'hF, '0);
    c_rd(33); for (int i = 0; i < 4; i++) cont(0, 1, 1, 4'hF, '0);
    burst_linear = 1;

    phase = "R3 processor strobe ignored";
    c_rd(36);
    set_idle(); pstb_n = 0; sel1_n = 1; addr = AW'(0); adv_n = 0; tick();
    cont(0, 1, 1, 4'hF, '0);
    desel();
    set_idle(); pstb_n = 0; sel1_n = 1; addr = AW'(9); tick(); tick(); tick();
    set_idle(); pstb_n = 0; cstb_n = 0; sel1_n = 1; addr = AW'(9); tick();
    c_rd(9); c_rd(10); c_rd(11);

    phase = "R11 output enable";
    c_rd(14); oe_n = 1; c_rd(15); c_rd(16);
    oe_n = 0; #0.5; check_now();
    c_rd(17); oe_n = 1; #0.5; check_now();
    oe_n = 0; c_rd(18); c_rd(19);

    phase = "R6 R4 R5 readback";
    desel();
    for (int a = 0; a < WORDS; a++) c_rd(a);
    set_idle(); tick(); tick();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule